// File: doc/BRIEF.md
# DRAM Training Command Sequencer

This block replays a short, software-loaded program of DRAM commands for memory training and memory test. The program has up to four slots. Each slot names one command (activate, read, write, precharge, mode-register set, ZQ short calibration or no-op), how many times to issue it, the idle cycles between issues, and the idle cycles after its final issue. It also holds a data-direction tag, a start address, bank and rank, and two auto-update options. The column option adds 8 to the address after each issue and can wrap at a chosen bit. The bank option steps to the next bank after each issue. With these options, a long run of activates, writes or reads needs no software action.

Software writes slots one at a time through a configuration port while the engine is idle. A start pulse selects the last slot to run and a replay count. The engine then walks the slots in order. On each issue cycle it drives command, address, bank, rank and direction on the command bus with a valid strobe. Every pass through the program reloads each slot's start address and bank. The block does not model data capture, PHY delays or DRAM timing legality. A precharge-all is simply a precharge with address 1024, so bit 10 is set. A mode-register write simply carries bank 3 and the mode value as its address.

Top module: `trn_cmd_seq`

## Requirements
- R1: After reset, busy, done and cmd_valid are 0 and cmd_op reads 0 (NOP).
- R2: Slots 0 through last_slot run in ascending order. Each slot issues its command max(count,1) times with its own op, rank and direction. Op codes: NOP=0, ACT=1, RD=2, WR=3, PRE=4, MRS=5, ZQCS=6. Direction codes: none=0, read=1, write=2.
- R3: Two successive issues within one slot are exactly gap+1 cycles apart.
- R4: The first issue of the next slot, or of the next pass, comes exactly post+1 cycles after the last issue of the current slot.
- R5: With column increment set, the address grows by 8 after every issue. If the wrap value w is between 1 and 15, only bits below w change and bits w and above keep their start value. A wrap value of 0, or of 16 or more, gives plain 16-bit rollover.
- R6: With bank increment set, the bank grows by one after every issue and rolls over modulo 8.
- R7: With neither increment set, every issue carries the slot's address and bank unchanged. This includes a PRE with address 1024 and an MRS with bank 3 and address 4.
- R8: A replay count L runs the whole program L+1 times. Every pass starts each slot again from its programmed address and bank.
- R9: The first issue appears in the cycle after start is sampled. done is a one-cycle pulse that comes post+1 cycles after the final issue. busy is high from the first issue until done and is low in the done cycle.
- R10: A start pulse while busy is ignored: the running program, its order and its timing do not change.
- R11: In any cycle without an issue, cmd_valid is 0, cmd_op is NOP and cmd_dir is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one slot descriptor |
| cfg_slot | input | 2 | Slot written |
| cfg_op | input | 3 | Command code |
| cfg_count | input | 9 | Issue count (0 acts as 1) |
| cfg_gap | input | 8 | Idle cycles between issues |
| cfg_post | input | 8 | Idle cycles after the final issue |
| cfg_dir | input | 2 | Data-direction tag |
| cfg_addr | input | 16 | Start address |
| cfg_bank | input | 3 | Start bank |
| cfg_rank | input | 2 | Target rank |
| cfg_inc_col | input | 1 | Add 8 to the address per issue |
| cfg_inc_bank | input | 1 | Step the bank per issue |
| cfg_wrap | input | 5 | Address wrap bit (0 means none) |
| start | input | 1 | Begin the program when idle |
| last_slot | input | 2 | Highest slot executed |
| loop_cnt | input | 4 | Extra passes of the program |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 3 | Command code |
| cmd_addr | output | 16 | Address |
| cmd_bank | output | 3 | Bank |
| cmd_rank | output | 2 | Rank |
| cmd_dir | output | 2 | Data-direction strobe |

## Verification
The bench sweeps every combination of gap and post from 0 to 3. A design that mixes up the two counters, or that is off by one cycle in either, moves an issue time against the model. The wrap sweep covers a wrap of 3, which must freeze the address, and wraps at the top width and beyond it. A faulty mask would let carries leak into the upper bits or truncate the address. Other runs cover a four-slot program with two replays and a start poked in mid-run, a zero count and a 480-issue slot. These catch a failure to reload the start address per pass, a design that restarts on a busy start, and a count that is off by one at its extremes.

// File: rtl/trn_seq_pkg.sv
package trn_seq_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_MRS  = 3'd5,
        OP_ZQCS = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_RD   = 2'd1,
        DIR_WR   = 2'd2
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

endpackage

// File: rtl/trn_slot_file.sv
module trn_slot_file #(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int RANK_W = 2,
    parameter int CNT_W  = 9,
    parameter int TIME_W = 8,
    parameter int WRAP_W = 5,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [2:0]        wr_op,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [TIME_W-1:0] wr_gap,
    input  logic [TIME_W-1:0] wr_post,
    input  logic [1:0]        wr_dir,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [RANK_W-1:0] wr_rank,
    input  logic              wr_inc_col,
    input  logic              wr_inc_bank,
    input  logic [WRAP_W-1:0] wr_wrap,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [2:0]        rd_op,
    output logic [TIME_W-1:0] rd_gap,
    output logic [TIME_W-1:0] rd_post,
    output logic [1:0]        rd_dir,
    output logic [RANK_W-1:0] rd_rank,
    output logic              rd_inc_col,
    output logic              rd_inc_bank,
    output logic [WRAP_W-1:0] rd_wrap,
    input  logic [SLOT_W-1:0] ld_idx,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [BANK_W-1:0] ld_bank,
    output logic [CNT_W-1:0]  ld_cnt
);

    typedef struct packed {
        logic [2:0]        op;
        logic [CNT_W-1:0]  cnt;
        logic [TIME_W-1:0] gap;
        logic [TIME_W-1:0] post;
        logic [1:0]        dir;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic [RANK_W-1:0] rank;
        logic              inc_col;
        logic              inc_bank;
        logic [WRAP_W-1:0] wrap;
    } slot_t;

    slot_t wr_ent;
    slot_t tbl [SLOTS];

    assign wr_ent = '{op: wr_op, cnt: wr_cnt, gap: wr_gap, post: wr_post,
                      dir: wr_dir, addr: wr_addr, bank: wr_bank, rank: wr_rank,
                      inc_col: wr_inc_col, inc_bank: wr_inc_bank, wrap: wr_wrap};

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        slot_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && wr_slot == SLOT_W'(g)) begin
                ent_d = wr_ent;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign tbl[g] = ent_q;
    end

    assign rd_op       = tbl[rd_idx].op;
    assign rd_gap      = tbl[rd_idx].gap;
    assign rd_post     = tbl[rd_idx].post;
    assign rd_dir      = tbl[rd_idx].dir;
    assign rd_rank     = tbl[rd_idx].rank;
    assign rd_inc_col  = tbl[rd_idx].inc_col;
    assign rd_inc_bank = tbl[rd_idx].inc_bank;
    assign rd_wrap     = tbl[rd_idx].wrap;
    assign ld_addr     = tbl[ld_idx].addr;
    assign ld_bank     = tbl[ld_idx].bank;
    assign ld_cnt      = tbl[ld_idx].cnt;

endmodule

// File: rtl/trn_addr_step.sv
module trn_addr_step #(
    parameter int ADDR_W   = 16,
    parameter int BANK_W   = 3,
    parameter int WRAP_W   = 5,
    parameter int COL_STEP = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic              inc_col,
    input  logic              inc_bank,
    input  logic [WRAP_W-1:0] wrap,
    output logic [ADDR_W-1:0] addr_nx,
    output logic [BANK_W-1:0] bank_nx
);

    logic [ADDR_W-1:0] hold_mask;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        hold_mask = '0;
        if (wrap != '0 && wrap < WRAP_W'(ADDR_W)) begin
            hold_mask = ~((ADDR_W'(1) << wrap) - ADDR_W'(1));
        end
        sum     = addr + ADDR_W'(COL_STEP);
        addr_nx = inc_col ? ((addr & hold_mask) | (sum & ~hold_mask)) : addr;
        bank_nx = inc_bank ? bank + BANK_W'(1) : bank;
    end

endmodule

// File: rtl/trn_cmd_seq.sv
module trn_cmd_seq
    import trn_seq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int RANK_W = 2,
    parameter int CNT_W  = 9,
    parameter int TIME_W = 8,
    parameter int LOOP_W = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int WRAP_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [2:0]        cfg_op,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [TIME_W-1:0] cfg_gap,
    input  logic [TIME_W-1:0] cfg_post,
    input  logic [1:0]        cfg_dir,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [RANK_W-1:0] cfg_rank,
    input  logic              cfg_inc_col,
    input  logic              cfg_inc_bank,
    input  logic [WRAP_W-1:0] cfg_wrap,
    input  logic              start,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic [LOOP_W-1:0] loop_cnt,
    output logic              busy,
    output logic              done,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [1:0]        cmd_dir
);

    typedef struct packed {
        st_e               st;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] last;
        logic [LOOP_W-1:0] loop;
        logic [CNT_W-1:0]  rep;
        logic [TIME_W-1:0] wait_cnt;
        logic              in_post;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [2:0]        cur_op;
    logic [TIME_W-1:0] cur_gap, cur_post;
    logic [1:0]        cur_dir;
    logic [RANK_W-1:0] cur_rank;
    logic              cur_inc_col, cur_inc_bank;
    logic [WRAP_W-1:0] cur_wrap;
    logic [SLOT_W-1:0] ld_idx;
    logic [ADDR_W-1:0] ld_addr, step_addr;
    logic [BANK_W-1:0] ld_bank, step_bank;
    logic [CNT_W-1:0]  ld_cnt, ld_rep;
    logic              advance;

    assign ld_idx = (seq_q.st == ST_IDLE || seq_q.slot == seq_q.last)
                    ? '0 : seq_q.slot + SLOT_W'(1);
    assign ld_rep = (ld_cnt == '0) ? '0 : ld_cnt - CNT_W'(1);

    trn_slot_file #(
        .SLOTS(SLOTS), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .RANK_W(RANK_W),
        .CNT_W(CNT_W), .TIME_W(TIME_W), .WRAP_W(WRAP_W)
    ) i_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_slot(cfg_slot), .wr_op(cfg_op), .wr_cnt(cfg_count),
        .wr_gap(cfg_gap), .wr_post(cfg_post), .wr_dir(cfg_dir), .wr_addr(cfg_addr),
        .wr_bank(cfg_bank), .wr_rank(cfg_rank), .wr_inc_col(cfg_inc_col),
        .wr_inc_bank(cfg_inc_bank), .wr_wrap(cfg_wrap),
        .rd_idx(seq_q.slot), .rd_op(cur_op), .rd_gap(cur_gap), .rd_post(cur_post),
        .rd_dir(cur_dir), .rd_rank(cur_rank), .rd_inc_col(cur_inc_col),
        .rd_inc_bank(cur_inc_bank), .rd_wrap(cur_wrap),
        .ld_idx(ld_idx), .ld_addr(ld_addr), .ld_bank(ld_bank), .ld_cnt(ld_cnt)
    );

    trn_addr_step #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .WRAP_W(WRAP_W), .COL_STEP(8)
    ) i_step (
        .addr(seq_q.addr), .bank(seq_q.bank), .inc_col(cur_inc_col),
        .inc_bank(cur_inc_bank), .wrap(cur_wrap),
        .addr_nx(step_addr), .bank_nx(step_bank)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        advance    = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st   = ST_ISSUE;
                    seq_d.slot = '0;
                    seq_d.last = last_slot;
                    seq_d.loop = loop_cnt;
                    seq_d.addr = ld_addr;
                    seq_d.bank = ld_bank;
                    seq_d.rep  = ld_rep;
                end
            end
            ST_ISSUE: begin
                if (seq_q.rep != '0) begin
                    seq_d.rep  = seq_q.rep - CNT_W'(1);
                    seq_d.addr = step_addr;
                    seq_d.bank = step_bank;
                    if (cur_gap != '0) begin
                        seq_d.st       = ST_WAIT;
                        seq_d.wait_cnt = cur_gap - TIME_W'(1);
                        seq_d.in_post  = 1'b0;
                    end
                end else if (cur_post != '0) begin
                    seq_d.st       = ST_WAIT;
                    seq_d.wait_cnt = cur_post - TIME_W'(1);
                    seq_d.in_post  = 1'b1;
                end else begin
                    advance = 1'b1;
                end
            end
            ST_WAIT: begin
                if (seq_q.wait_cnt != '0) begin
                    seq_d.wait_cnt = seq_q.wait_cnt - TIME_W'(1);
                end else if (seq_q.in_post) begin
                    advance = 1'b1;
                end else begin
                    seq_d.st = ST_ISSUE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (advance) begin
            if (seq_q.slot == seq_q.last && seq_q.loop == '0) begin
                seq_d.st   = ST_IDLE;
                seq_d.slot = '0;
                seq_d.done = 1'b1;
            end else begin
                if (seq_q.slot == seq_q.last) begin
                    seq_d.loop = seq_q.loop - LOOP_W'(1);
                end
                seq_d.st   = ST_ISSUE;
                seq_d.slot = ld_idx;
                seq_d.addr = ld_addr;
                seq_d.bank = ld_bank;
                seq_d.rep  = ld_rep;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy      = (seq_q.st != ST_IDLE);
    assign done      = seq_q.done;
    assign cmd_valid = (seq_q.st == ST_ISSUE);
    assign cmd_op    = cmd_valid ? cur_op : OP_NOP;
    assign cmd_dir   = cmd_valid ? cur_dir : DIR_NONE;
    assign cmd_addr  = seq_q.addr;
    assign cmd_bank  = seq_q.bank;
    assign cmd_rank  = cur_rank;

endmodule

// File: rtl/trn_cmd_seq_chk.sv
module trn_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [1:0] cmd_dir
);

    p_idle_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_clears_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_issues_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> cmd_valid);

    p_busy_ends_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_op == 3'd0 && cmd_dir == 2'd0));

endmodule

bind trn_cmd_seq trn_cmd_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dir(cmd_dir)
);

// File: tb/test_trn_cmd_seq.sv
module test_trn_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_EV     = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [2:0]  cfg_op = '0;
    logic [8:0]  cfg_count = '0;
    logic [7:0]  cfg_gap = '0;
    logic [7:0]  cfg_post = '0;
    logic [1:0]  cfg_dir = '0;
    logic [15:0] cfg_addr = '0;
    logic [2:0]  cfg_bank = '0;
    logic [1:0]  cfg_rank = '0;
    logic        cfg_inc_col = 1'b0;
    logic        cfg_inc_bank = 1'b0;
    logic [4:0]  cfg_wrap = '0;
    logic        start = 1'b0;
    logic [1:0]  last_slot = '0;
    logic [3:0]  loop_cnt = '0;
    logic        busy, done, cmd_valid;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_addr;
    logic [2:0]  cmd_bank;
    logic [1:0]  cmd_rank;
    logic [1:0]  cmd_dir;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    int m_op[4], m_cnt[4], m_gap[4], m_post[4], m_dir[4];
    int m_addr[4], m_bank[4], m_rank[4], m_ic[4], m_ib[4], m_wrap[4];

    int e_t[MAX_EV], e_op[MAX_EV], e_a[MAX_EV], e_b[MAX_EV], e_r[MAX_EV], e_d[MAX_EV];
    string e_ttag[MAX_EV], e_atag[MAX_EV], e_btag[MAX_EV];
    int o_t[MAX_EV], o_op[MAX_EV], o_a[MAX_EV], o_b[MAX_EV], o_r[MAX_EV], o_d[MAX_EV];

    trn_cmd_seq i_trn_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_op(cfg_op), .cfg_count(cfg_count), .cfg_gap(cfg_gap),
        .cfg_post(cfg_post), .cfg_dir(cfg_dir), .cfg_addr(cfg_addr),
        .cfg_bank(cfg_bank), .cfg_rank(cfg_rank), .cfg_inc_col(cfg_inc_col),
        .cfg_inc_bank(cfg_inc_bank), .cfg_wrap(cfg_wrap), .start(start),
        .last_slot(last_slot), .loop_cnt(loop_cnt), .busy(busy), .done(done),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_bank(cmd_bank), .cmd_rank(cmd_rank), .cmd_dir(cmd_dir)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int col_next(input int a, input int w);
        int span;
        if (w == 0 || w >= 16) return (a + 8) % 65536;
        span = 1 << w;
        return (a - (a % span)) + (((a % span) + 8) % span);
    endfunction

    task automatic load(input int s, input int op, input int cnt, input int gap,
                        input int post, input int dir, input int addr, input int bank,
                        input int rank, input int ic, input int ib, input int wr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 2'(s); cfg_op = 3'(op); cfg_count = 9'(cnt);
        cfg_gap = 8'(gap); cfg_post = 8'(post); cfg_dir = 2'(dir);
        cfg_addr = 16'(addr); cfg_bank = 3'(bank); cfg_rank = 2'(rank);
        cfg_inc_col = ic[0]; cfg_inc_bank = ib[0]; cfg_wrap = 5'(wr);
        m_op[s] = op; m_cnt[s] = cnt; m_gap[s] = gap; m_post[s] = post; m_dir[s] = dir;
        m_addr[s] = addr; m_bank[s] = bank; m_rank[s] = rank;
        m_ic[s] = ic; m_ib[s] = ib; m_wrap[s] = wr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_queue(input int last, input int nloops, input bit poke);
        int k = 0;
        int t_exp = 0;
        int n_obs = 0;
        int done_t = -1;
        for (int p = 0; p <= nloops; p++) begin
            for (int s = 0; s <= last; s++) begin
                int n = (m_cnt[s] == 0) ? 1 : m_cnt[s];
                int a = m_addr[s];
                int b = m_bank[s];
                for (int i = 0; i < n; i++) begin
                    e_t[k] = t_exp; e_op[k] = m_op[s]; e_a[k] = a; e_b[k] = b;
                    e_r[k] = m_rank[s]; e_d[k] = m_dir[s];
                    e_ttag[k] = (k == 0) ? "R9" : ((i == 0) ? "R4" : "R3");
                    e_atag[k] = (p > 0) ? "R8" : (m_ic[s] != 0 ? "R5" : "R7");
                    e_btag[k] = (p > 0) ? "R8" : (m_ib[s] != 0 ? "R6" : "R7");
                    k++;
                    if (i < n - 1) begin
                        t_exp += m_gap[s] + 1;
                        if (m_ic[s] != 0) a = col_next(a, m_wrap[s]);
                        if (m_ib[s] != 0) b = (b + 1) % 8;
                    end else begin
                        t_exp += m_post[s] + 1;
                    end
                end
            end
        end

        @(negedge clk);
        start = 1'b1; last_slot = 2'(last); loop_cnt = 4'(nloops);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 20000; t++) begin
            if (poke && t == 2) begin start = 1'b1; last_slot = 2'd0; loop_cnt = 4'd0; end
            if (poke && t == 3) start = 1'b0;
            if (cmd_valid && n_obs < MAX_EV) begin
                o_t[n_obs] = t; o_op[n_obs] = int'(cmd_op); o_a[n_obs] = int'(cmd_addr);
                o_b[n_obs] = int'(cmd_bank); o_r[n_obs] = int'(cmd_rank); o_d[n_obs] = int'(cmd_dir);
                n_obs++;
            end else if (!cmd_valid) begin
                if (cmd_op != 3'd0 || cmd_dir != 2'd0) begin
                    check("R11", "idle-cycle op/dir nonzero", 1, 0);
                end
            end
            if (done) begin
                done_t = t;
                break;
            end
            if (!busy) begin
                check("R9", "busy low before done", 0, 1);
                break;
            end
            @(negedge clk);
        end

        check(poke ? "R10" : "R2", "issue count", n_obs, k);
        check("R9", "done cycle", done_t, t_exp);
        for (int i = 0; i < k && i < n_obs; i++) begin
            check(e_ttag[i], "issue cycle", o_t[i], e_t[i]);
            check("R2", "op", o_op[i], e_op[i]);
            check("R2", "rank", o_r[i], e_r[i]);
            check("R2", "dir", o_d[i], e_d[i]);
            check(e_atag[i], "address", o_a[i], e_a[i]);
            check(e_btag[i], "bank", o_b[i], e_b[i]);
        end
        @(negedge clk);
        check("R9", "done after pulse", int'(done), 0);
        check("R9", "busy after done", int'(busy), 0);
        check("R11", "valid when idle", int'(cmd_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL R9 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "valid in reset", int'(cmd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "valid after reset", int'(cmd_valid), 0);
        check("R1", "op after reset", int'(cmd_op), 0);

        // R3 R4 R6: gap and post sweep, bank wraps past 7
        for (int g = 0; g < 4; g++) begin
            for (int p = 0; p < 4; p++) begin
                load(0, 1, 3, g, p, 0, 40, 6, 1, 0, 1, 0);
                load(1, 3, 2, p, g, 2, 16, 2, 3, 1, 0, 0);
                run_queue(1, 0, 1'b0);
            end
        end

        // R5: wrap sweep on a column-stepping read
        foreach (m_wrap[i]) m_wrap[i] = 0;
        for (int w = 0; w < 8; w++) begin
            int wv = (w < 6) ? w + 2 : ((w == 6) ? 16 : 20);
            load(0, 2, 6, 0, 1, 1, 16'hFFF0 - 16'h05E0, 5, 2, 1, 0, wv);
            run_queue(0, 0, 1'b0);
        end
        load(0, 2, 5, 1, 0, 1, 16'hFFF0, 0, 0, 1, 0, 0);
        run_queue(0, 0, 1'b0);

        // R7 R8 R10: four-slot program, replayed, with a start poked mid-run
        load(0, 5, 1, 0, 3, 0, 4, 3, 2, 0, 0, 0);
        load(1, 2, 4, 2, 2, 1, 0, 0, 2, 1, 1, 10);
        load(2, 4, 1, 0, 1, 0, 1024, 0, 2, 0, 0, 0);
        load(3, 6, 2, 1, 0, 0, 0, 7, 2, 0, 0, 0);
        run_queue(3, 2, 1'b1);
        run_queue(2, 0, 1'b0);

        // R2: zero count issues once; NOP slot; long 480-issue write slot
        load(0, 0, 0, 0, 2, 2, 8, 1, 1, 1, 1, 0);
        load(1, 3, 480, 0, 4, 2, 0, 0, 0, 1, 0, 0);
        run_queue(1, 1, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule